// File: doc/BRIEF.md
# UART Bit-Rate and Frame Configuration

This block holds the three configuration words of a UART channel (line control, integer divisor and fractional divisor) and turns them into the timing and framing information the serializer and deserializer need. It produces two enables from the reference clock. The first is an oversample tick at sixteen times the bit rate, for receiver sampling. The second is a bit tick once per bit period. It also decodes the data length, the parity mode, the stop-bit count, the infrared select and the total frame length in bits.

One bit period lasts 16 × divisor + fraction + 16 reference clocks. The block splits this period into sixteen oversample intervals. The first `fraction` intervals are one clock longer than the others, so the fractional part is spread across the bit rather than collected at its end. A divisor of zero means the rate is not programmed, and both ticks then stay low. Any write to a configuration word restarts the tick counters, so the new timing applies from the write onward. With a 24 MHz reference clock, divisor 12 and fraction 0 give a period of 208 clocks, which is roughly 115.4 kbit/s.

Top module: `uart_baud_frame_cfg`

## Requirements
- R1: After reset both ticks are low, the divisor is 0, and the decoded frame is 5 data bits, no parity, 1 stop bit, infrared off and a frame size of 7.
- R2: With a non-zero divisor D and fraction F, the first bit tick comes exactly 16·D+F+16 clocks after the clock edge of the last configuration write, and later bit ticks repeat with that same period.
- R3: Each bit period holds exactly 16 oversample ticks, and every bit tick coincides with an oversample tick.
- R4: Within a bit period, oversample intervals 0 to F−1 last D+2 clocks and the others last D+1 clocks.
- R5: While the divisor is 0, neither tick is ever asserted.
- R6: A write to any of the three configuration words restarts counting: no tick in the cycle after the write, and the next bit tick follows the full R2 delay measured from that write.
- R7: The data length output equals line-control bits [1:0] plus 5 (5 to 8).
- R8: Line-control bit 2 set selects two stop bits; clear selects one.
- R9: Line-control bit 5 enables parity. Bit 3 selects even parity (set) or odd parity (clear). The even-parity output is low whenever parity is disabled, so bit 3 has no effect without bit 5. Bits 4 and 7 are ignored.
- R10: Line-control bit 6 is passed out as the infrared-mode select.
- R11: Frame size = 1 start bit + data bits + 1 if parity is enabled + stop bits (7 to 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lcr_wr | input | 1 | Write strobe for the line-control word |
| lcr_wdata | input | 8 | Line-control write data |
| div_wr | input | 1 | Write strobe for the integer divisor |
| div_wdata | input | 16 | Integer divisor write data |
| frac_wr | input | 1 | Write strobe for the fractional divisor |
| frac_wdata | input | 3 | Fractional divisor write data |
| os_tick | output | 1 | Oversample enable, 16 per bit period |
| bit_tick | output | 1 | Bit-rate enable |
| data_bits | output | 4 | Data length in bits |
| parity_en | output | 1 | Parity bit present |
| parity_even | output | 1 | Even parity selected (only when parity is enabled) |
| stop_two | output | 1 | Two stop bits |
| ir_mode | output | 1 | Infrared mode select |
| frame_bits | output | 4 | Total frame length in bits |

## Verification
The timing path is exercised with several divisor and fraction pairs: fraction zero, fraction at its maximum of 7, and mid values. A wrong bias, a missing fraction or misplaced long intervals each shows up as a mismatch in the first-tick delay, the steady period or the spacing of individual oversample ticks. The line-control decode is walked through words that vary one field at a time, plus words with ignored bits set. These separate a swapped stop/parity bit, an even-parity flag that leaks without parity, and a frame sum that omits a term. Directed cases cover a zero divisor holding the ticks low, and a rewrite in mid-period, which must push the next bit tick out by a whole period rather than letting the old count finish.

// File: rtl/bfc_pkg.sv
// Package: shared widths, line-control field positions and the decoded
// frame record used by the bit-rate/frame configuration block.
package bfc_pkg;
    localparam int LCR_W       = 8;
    localparam int LEN_LSB     = 0;   // two-bit data-length field
    localparam int STOP_POS    = 2;
    localparam int EVEN_POS    = 3;
    localparam int PAR_POS     = 5;
    localparam int IR_POS      = 6;
    localparam int MIN_DATA    = 5;
    localparam int FIELD_W     = 4;

    typedef struct packed {
        logic [FIELD_W-1:0] data_bits;
        logic               parity_en;
        logic               parity_even;
        logic               stop_two;
        logic               ir_mode;
        logic [FIELD_W-1:0] frame_bits;
    } frame_cfg_t;
endpackage

// File: rtl/bfc_cfg_regs.sv
// Configuration store: holds the line-control word, the integer divisor and
// the fractional divisor. It flags a restart in any cycle that writes one of
// them. Assumes write strobes are single-cycle and synchronous to clk.
module bfc_cfg_regs #(
    parameter int LCR_W  = 8,
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcr_wr,
    input  logic [LCR_W-1:0]  lcr_wdata,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              frac_wr,
    input  logic [FRAC_W-1:0] frac_wdata,
    output logic [LCR_W-1:0]  lcr_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic              restart
);
    // Any configuration write restarts the tick counters.
    always_comb restart = lcr_wr | div_wr | frac_wr;

    // Register the three words; all reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q  <= '0;
            div_q  <= '0;
            frac_q <= '0;
        end else begin
            if (lcr_wr)  lcr_q  <= lcr_wdata;
            if (div_wr)  div_q  <= div_wdata;
            if (frac_wr) frac_q <= frac_wdata;
        end
    end
endmodule

// File: rtl/bfc_tick_gen.sv
// Tick generator: splits a bit period of OS_RATE*(div+1)+frac clocks into
// OS_RATE oversample intervals. The first frac intervals are one clock
// longer. It pulses os_tick at the end of each interval and bit_tick at the
// end of the last one. Assumes FRAC_W <= log2(OS_RATE) and a divisor of zero
// means "halted".
module bfc_tick_gen #(
    parameter int DIV_W   = 16,
    parameter int FRAC_W  = 3,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div_q,
    input  logic [FRAC_W-1:0] frac_q,
    output logic              os_tick,
    output logic              bit_tick
);
    localparam int IDX_W = $clog2(OS_RATE);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OS_RATE - 1);

    logic [CNT_W-1:0] sub_cnt;
    logic [IDX_W-1:0] os_idx;
    logic             halt;
    logic             long_slot;
    logic [CNT_W-1:0] last_cnt;

    // A zero divisor leaves the rate unprogrammed.
    always_comb halt = (div_q == '0);

    // Early intervals absorb the fractional clocks, one each.
    always_comb long_slot = ({1'b0, os_idx} < (IDX_W+1)'(frac_q));

    // Terminal count of the current interval (length minus one).
    always_comb last_cnt = CNT_W'(div_q) + CNT_W'(long_slot);

    // Count clocks within an interval and intervals within a bit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || halt) begin
            sub_cnt  <= '0;
            os_idx   <= '0;
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else if (sub_cnt == last_cnt) begin
            sub_cnt  <= '0;
            os_idx   <= (os_idx == LAST_IDX) ? '0 : os_idx + 1'b1;
            os_tick  <= 1'b1;
            bit_tick <= (os_idx == LAST_IDX);
        end else begin
            sub_cnt  <= sub_cnt + 1'b1;
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end
    end
endmodule

// File: rtl/bfc_frame_decode.sv
// Frame decoder: derives data length, parity mode, stop count, infrared
// select and total frame length from the line-control word. Purely
// combinational; assumes the word is already registered.
module bfc_frame_decode
    import bfc_pkg::*;
#(
    parameter int LCR_W = bfc_pkg::LCR_W
) (
    input  logic [LCR_W-1:0] lcr_q,
    output frame_cfg_t       cfg
);
    logic [FIELD_W-1:0] stop_cnt;

    // Decode each field and sum the frame length.
    always_comb begin
        cfg.data_bits   = FIELD_W'(lcr_q[LEN_LSB +: 2]) + FIELD_W'(MIN_DATA);
        cfg.stop_two    = lcr_q[STOP_POS];
        cfg.parity_en   = lcr_q[PAR_POS];
        cfg.parity_even = lcr_q[PAR_POS] & lcr_q[EVEN_POS];
        cfg.ir_mode     = lcr_q[IR_POS];
        stop_cnt        = cfg.stop_two ? FIELD_W'(2) : FIELD_W'(1);
        cfg.frame_bits  = FIELD_W'(1) + cfg.data_bits
                        + FIELD_W'(cfg.parity_en) + stop_cnt;
    end
endmodule

// File: rtl/uart_baud_frame_cfg.sv
// Top: UART bit-rate and frame configuration. It stores the line-control,
// divisor and fraction words, generates the oversample and bit ticks, and
// exposes the decoded frame parameters. Assumes a free-running reference
// clock and a synchronous active-low reset.
module uart_baud_frame_cfg
    import bfc_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int FRAC_W  = 3,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcr_wr,
    input  logic [7:0]        lcr_wdata,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              frac_wr,
    input  logic [FRAC_W-1:0] frac_wdata,
    output logic              os_tick,
    output logic              bit_tick,
    output logic [3:0]        data_bits,
    output logic              parity_en,
    output logic              parity_even,
    output logic              stop_two,
    output logic              ir_mode,
    output logic [3:0]        frame_bits
);
    logic [LCR_W-1:0]  lcr_q;
    logic [DIV_W-1:0]  div_q;
    logic [FRAC_W-1:0] frac_q;
    logic              restart;
    frame_cfg_t        cfg;

    bfc_cfg_regs #(.LCR_W(LCR_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .lcr_wr(lcr_wr), .lcr_wdata(lcr_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .frac_wr(frac_wr), .frac_wdata(frac_wdata),
        .lcr_q(lcr_q), .div_q(div_q), .frac_q(frac_q),
        .restart(restart)
    );

    bfc_tick_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .OS_RATE(OS_RATE)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .div_q(div_q), .frac_q(frac_q),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    bfc_frame_decode #(.LCR_W(LCR_W)) u_dec (
        .lcr_q(lcr_q), .cfg(cfg)
    );

    // Drive the decoded record onto the individual output ports.
    always_comb begin
        data_bits   = cfg.data_bits;
        parity_en   = cfg.parity_en;
        parity_even = cfg.parity_even;
        stop_two    = cfg.stop_two;
        ir_mode     = cfg.ir_mode;
        frame_bits  = cfg.frame_bits;
    end
endmodule

// File: rtl/bfc_checker.sv
// Checker: temporal properties of the configuration block, bound to the top.
module bfc_checker #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lcr_wr,
    input logic             div_wr,
    input logic             frac_wr,
    input logic [DIV_W-1:0] div_q,
    input logic             os_tick,
    input logic             bit_tick,
    input logic [3:0]       data_bits,
    input logic             parity_en,
    input logic             parity_even,
    input logic             stop_two,
    input logic [3:0]       frame_bits
);
    a_r3_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    a_r4_os_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |=> !os_tick);

    a_r5_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |=> (!os_tick && !bit_tick));

    a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_wr || div_wr || frac_wr) |=> (!os_tick && !bit_tick));

    a_r7_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        (data_bits >= 4'd5) && (data_bits <= 4'd8));

    a_r9_even_needs_par: assert property (@(posedge clk) disable iff (!rst_n)
        parity_even |-> parity_en);

    a_r11_frame_sum: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bits == 4'd1 + data_bits + {3'd0, parity_en} + (stop_two ? 4'd2 : 4'd1));
endmodule

bind uart_baud_frame_cfg bfc_checker #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lcr_wr(lcr_wr), .div_wr(div_wr), .frac_wr(frac_wr),
    .div_q(div_q), .os_tick(os_tick), .bit_tick(bit_tick),
    .data_bits(data_bits), .parity_en(parity_en), .parity_even(parity_even),
    .stop_two(stop_two), .frame_bits(frame_bits)
);

// File: tb/tb_uart_baud_frame_cfg.sv
module tb_uart_baud_frame_cfg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lcr_wr = 1'b0, div_wr = 1'b0, frac_wr = 1'b0;
    logic [7:0]  lcr_wdata = '0;
    logic [15:0] div_wdata = '0;
    logic [2:0]  frac_wdata = '0;
    logic        os_tick, bit_tick, parity_en, parity_even, stop_two, ir_mode;
    logic [3:0]  data_bits, frame_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_baud_frame_cfg dut (
        .clk(clk), .rst_n(rst_n),
        .lcr_wr(lcr_wr), .lcr_wdata(lcr_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .frac_wr(frac_wr), .frac_wdata(frac_wdata),
        .os_tick(os_tick), .bit_tick(bit_tick),
        .data_bits(data_bits), .parity_en(parity_en), .parity_even(parity_even),
        .stop_two(stop_two), .ir_mode(ir_mode), .frame_bits(frame_bits)
    );

    // {lcr, data_bits, parity_en, parity_even, stop_two, ir_mode, frame_bits}
    localparam int NLCR = 10;
    localparam logic [19:0] LCR_VEC [NLCR] = '{
        {8'h00, 4'd5, 4'b0000, 4'd7},
        {8'h03, 4'd8, 4'b0000, 4'd10},
        {8'h07, 4'd8, 4'b0010, 4'd11},
        {8'h2B, 4'd8, 4'b1100, 4'd11},
        {8'h21, 4'd6, 4'b1000, 4'd9},
        {8'h26, 4'd7, 4'b1010, 4'd11},
        {8'h40, 4'd5, 4'b0001, 4'd7},
        {8'h3E, 4'd7, 4'b1110, 4'd11},
        {8'h98, 4'd5, 4'b0000, 4'd7},
        {8'hFF, 4'd8, 4'b1111, 4'd12}
    };

    // {divisor, fraction}
    localparam int NBAUD = 5;
    localparam logic [18:0] BAUD_VEC [NBAUD] = '{
        {16'd1, 3'd0}, {16'd1, 3'd7}, {16'd2, 3'd3}, {16'd3, 3'd1}, {16'd5, 3'd5}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_lcr(input logic [7:0] v);
        @(negedge clk); lcr_wr = 1'b1; lcr_wdata = v;
        @(negedge clk); lcr_wr = 1'b0;
    endtask

    task automatic wr_div(input logic [15:0] v);
        @(negedge clk); div_wr = 1'b1; div_wdata = v;
        @(negedge clk); div_wr = 1'b0;
    endtask

    task automatic wr_frac(input logic [2:0] v);
        @(negedge clk); frac_wr = 1'b1; frac_wdata = v;
        @(negedge clk); frac_wr = 1'b0;
    endtask

    // Called right after a write task returns (cycle count 0 = after write edge).
    task automatic measure(input int d, input int f);
        int p;
        int c;
        int last_os;
        int os_n;
        int first_bit;
        int second_bit;
        int os_in_second;
        int bad_gap;
        int bad_gap_val;
        p = 16 * d + f + 16;
        c = 0; last_os = 0; os_n = 0; first_bit = -1; second_bit = -1;
        os_in_second = 0; bad_gap = 0; bad_gap_val = 0;
        chk(!os_tick && !bit_tick, "R6 quiet after write", int'(os_tick), 0);
        while (second_bit < 0 && c < 4000) begin
            @(negedge clk);
            c++;
            if (os_tick) begin
                if (first_bit < 0) begin
                    if ((c - last_os) != (d + 1 + ((os_n < f) ? 1 : 0))) begin
                        bad_gap++;
                        bad_gap_val = c - last_os;
                    end
                    os_n++;
                end else begin
                    os_in_second++;
                end
                last_os = c;
            end
            if (bit_tick) begin
                if (first_bit < 0) first_bit = c;
                else second_bit = c;
            end
        end
        chk(first_bit == p, "R2 first bit tick delay", first_bit, p);
        chk((second_bit - first_bit) == p, "R2 bit period", second_bit - first_bit, p);
        chk(os_in_second == 16, "R3 os ticks per bit", os_in_second, 16);
        chk(bad_gap == 0, "R4 os interval length", bad_gap_val, d + 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!os_tick && !bit_tick, "R1 ticks low", int'(os_tick | bit_tick), 0);
        chk(data_bits == 4'd5 && !parity_en && !stop_two && !ir_mode,
            "R1 frame defaults", int'(data_bits), 5);
        chk(frame_bits == 4'd7, "R1 frame size", int'(frame_bits), 7);

        // R5 halted after reset: divisor 0
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (os_tick || bit_tick) seen++;
            end
            chk(seen == 0, "R5 no ticks at divisor 0 after reset", seen, 0);
        end

        // Line-control table: R7 R8 R9 R10 R11
        for (int i = 0; i < NLCR; i++) begin
            logic [19:0] v;
            v = LCR_VEC[i];
            wr_lcr(v[19:12]);
            chk(data_bits == v[11:8], "R7 data length", int'(data_bits), int'(v[11:8]));
            chk(parity_en == v[7] && parity_even == v[6], "R9 parity mode",
                int'({parity_en, parity_even}), int'(v[7:6]));
            chk(stop_two == v[5], "R8 stop bits", int'(stop_two), int'(v[5]));
            chk(ir_mode == v[4], "R10 infrared select", int'(ir_mode), int'(v[4]));
            chk(frame_bits == v[3:0], "R11 frame size", int'(frame_bits), int'(v[3:0]));
        end

        // Baud table: R2 R3 R4 R6
        for (int i = 0; i < NBAUD; i++) begin
            logic [18:0] b;
            b = BAUD_VEC[i];
            wr_div(b[18:3]);
            wr_frac(b[2:0]);
            measure(int'(b[18:3]), int'(b[2:0]));
        end

        // R6: mid-period rewrite pushes the bit tick out by a whole period
        wr_div(16'd1);
        wr_frac(3'd0);
        repeat (20) @(negedge clk);
        wr_lcr(8'h03);
        measure(1, 0);

        // R5: divisor set back to zero stops the ticks
        wr_div(16'd0);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (os_tick || bit_tick) seen++;
            end
            chk(seen == 0, "R5 no ticks after divisor cleared", seen, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule